// File: doc/BRIEF.md
# Translation Table Base Selector

This block turns a 32-bit virtual address into the physical address of its first-level page-table descriptor. Software keeps two table base registers and a 3-bit split value N. N divides the address space in two. An address whose top N bits are all zero is looked up through the low-region base. Any other address goes through the high-region base. The same split value also sets how finely the low-region base is aligned: a larger N allows a smaller, more finely aligned low table.

The descriptor address is combinational. It is formed from the address input and the stored registers. Register writes are accepted one per port and land on the next clock edge. The split value can be read back. Fetching the descriptor, second-level walks and translation caching are left to the surrounding logic.

Top module: `ttb_select`

## Requirements
- R1: After reset, N is 0 and both bases are 0. The read-back value is 0, the high-region flag is 0, and the descriptor address equals the index field alone.
- R2: A split-control write stores only wdata[2:0] as N. The read-back port returns N in bits [2:0] with all higher bits zero.
- R3: `base1_sel` is 1 exactly when (va & ~(0xFFFFFFFF >> N)) is non-zero. When N is 0 it is always 0.
- R4: When the low region is chosen, the base contributes (base0 & ~(0x3FFF >> N)).
- R5: When the high region is chosen, the base contributes (base1 & 0xFFFFC000), whatever the value of N.
- R6: The descriptor address is the masked base ORed with (va >> 18) & 0x3FFC. Bits [1:0] are always 0.
- R7: Base writes keep all 32 bits. Changing N later re-exposes base0 bits that were masked off before.
- R8: A write takes effect on the clock edge that samples it. In the cycle of the write, the outputs still reflect the old register values.
- R9: Writes to base0, base1 and the split control in the same cycle all take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| va_i | input | 32 | Virtual address to look up |
| base0_we | input | 1 | Write enable for the low-region base |
| base1_we | input | 1 | Write enable for the high-region base |
| ctrl_we | input | 1 | Write enable for the split control |
| wdata | input | 32 | Write data shared by all three registers |
| ctrl_rdata | output | 32 | Read-back of the stored split value N |
| desc_addr | output | 32 | First-level descriptor fetch address |
| base1_sel | output | 1 | 1 when the high-region base was used |

## Verification
A lookup and a split-control write can fall in the same cycle. A write can also change the region an address belongs to and the alignment of base0 at once. The bench provokes this by holding an address that lies in the high region under N=5 but in the low region under N=2, then writing N=2. It judges the result on two sides of the edge: before the edge the flag and the address must still follow N=5, and after it they must follow N=2. A second case writes all three registers in one cycle and checks lookups in both regions against the new values.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

   typedef enum logic {
      TTB_SEL_LOW  = 1'b0,
      TTB_SEL_HIGH = 1'b1
   } ttb_sel_e;

   // Ones in the low ALIGN bits of a W-bit word, for W up to 64.
   function automatic logic [63:0] low_ones(input int unsigned bits);
      logic [63:0] r;
      r = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < int'(bits)) r[i] = 1'b1;
      end
      return r;
   endfunction

endpackage

// File: rtl/ttb_cfg_regs.sv
module ttb_cfg_regs
   import ttb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned SPLIT_W    = 3,
   parameter int unsigned ALIGN_BITS = 14,
   parameter bit          STORE_MASK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base0_we,
   input  logic              base1_we,
   input  logic              ctrl_we,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] base0_q,
   output logic [ADDR_W-1:0] base1_q,
   output logic [SPLIT_W-1:0] split_n,
   output logic [ADDR_W-1:0] base0_mask
);

   localparam logic [63:0]       ONES64    = low_ones(ALIGN_BITS);
   localparam logic [ADDR_W-1:0] ALIGN_LOW = ONES64[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] MASK_RST  = ~ALIGN_LOW;

   // Full-width base storage; masking happens only at address formation.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base0_q <= '0;
         base1_q <= '0;
         split_n <= '0;
      end else begin
         if (base0_we) base0_q <= wdata;
         if (base1_we) base1_q <= wdata;
         if (ctrl_we)  split_n <= wdata[SPLIT_W-1:0];
      end
   end

   generate
      if (STORE_MASK) begin : g_mask_reg
         logic [ADDR_W-1:0] mask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mask_q <= MASK_RST;
            else if (ctrl_we) mask_q <= ~(ALIGN_LOW >> wdata[SPLIT_W-1:0]);
         end
         assign base0_mask = mask_q;

         // Stored mask and stored split value must always agree.
         p_mask_tracks_n_r4: assert property (@(posedge clk) disable iff (!rst_n)
            base0_mask == ~(ALIGN_LOW >> split_n));
      end else begin : g_mask_comb
         assign base0_mask = ~(ALIGN_LOW >> split_n);
      end
   endgenerate

   p_ctrl_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> split_n == $past(wdata[SPLIT_W-1:0]));

   p_base0_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      base0_we |=> base0_q == $past(wdata));

   p_base1_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !base1_we |=> $stable(base1_q));

   p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we |=> $stable(split_n));

endmodule

// File: rtl/ttb_region_sel.sv
module ttb_region_sel
   import ttb_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned SPLIT_W = 3
) (
   input  logic [ADDR_W-1:0]  va,
   input  logic [SPLIT_W-1:0] split_n,
   output ttb_sel_e           sel
);

   logic [ADDR_W-1:0] top_mask;

   always_comb begin
      top_mask = ~({ADDR_W{1'b1}} >> split_n);
      sel      = (|(va & top_mask)) ? TTB_SEL_HIGH : TTB_SEL_LOW;
   end

endmodule

// File: rtl/ttb_desc_addr.sv
module ttb_desc_addr
   import ttb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ALIGN_BITS = 14,
   parameter int unsigned IDX_LSB    = 2,
   localparam int unsigned IDX_W     = ALIGN_BITS - IDX_LSB
) (
   input  logic [IDX_W-1:0]  idx_bits,
   input  logic [ADDR_W-1:0] base0_q,
   input  logic [ADDR_W-1:0] base1_q,
   input  logic [ADDR_W-1:0] base0_mask,
   input  ttb_sel_e          sel,
   output logic [ADDR_W-1:0] desc_addr
);

   localparam logic [63:0]       ONES64    = low_ones(ALIGN_BITS);
   localparam logic [ADDR_W-1:0] HI_MASK   = ~ONES64[ADDR_W-1:0];

   logic [ADDR_W-1:0] base_m;
   logic [ADDR_W-1:0] idx_word;

   always_comb begin
      idx_word = {{(ADDR_W-ALIGN_BITS){1'b0}}, idx_bits, {IDX_LSB{1'b0}}};
      unique case (sel)
         TTB_SEL_HIGH: base_m = base1_q & HI_MASK;
         default:      base_m = base0_q & base0_mask;
      endcase
      desc_addr = base_m | idx_word;
   end

endmodule

// File: rtl/ttb_select.sv
module ttb_select
   import ttb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned SPLIT_W    = 3,
   parameter int unsigned ALIGN_BITS = 14,
   parameter int unsigned IDX_LSB    = 2,
   parameter bit          STORE_MASK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] va_i,
   input  logic              base0_we,
   input  logic              base1_we,
   input  logic              ctrl_we,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] ctrl_rdata,
   output logic [ADDR_W-1:0] desc_addr,
   output logic              base1_sel
);

   localparam int unsigned IDX_W   = ALIGN_BITS - IDX_LSB;
   localparam int unsigned N_MAX   = (1 << SPLIT_W) - 1;

   generate
      if (ADDR_W > 64 || ADDR_W <= ALIGN_BITS) begin : g_bad_width
         $error("ttb_select: ADDR_W must exceed ALIGN_BITS and be at most 64");
      end
      if (IDX_LSB >= ALIGN_BITS) begin : g_bad_idx
         $error("ttb_select: IDX_LSB must be below ALIGN_BITS");
      end
      if (N_MAX >= ALIGN_BITS || SPLIT_W == 0) begin : g_bad_split
         $error("ttb_select: split range must stay inside the alignment field");
      end
   endgenerate

   logic [ADDR_W-1:0]  base0_q, base1_q, base0_mask;
   logic [SPLIT_W-1:0] split_n;
   ttb_sel_e           sel;

   ttb_cfg_regs #(
      .ADDR_W(ADDR_W), .SPLIT_W(SPLIT_W),
      .ALIGN_BITS(ALIGN_BITS), .STORE_MASK(STORE_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .base0_we(base0_we), .base1_we(base1_we), .ctrl_we(ctrl_we),
      .wdata(wdata),
      .base0_q(base0_q), .base1_q(base1_q),
      .split_n(split_n), .base0_mask(base0_mask)
   );

   ttb_region_sel #(.ADDR_W(ADDR_W), .SPLIT_W(SPLIT_W)) u_sel (
      .va(va_i), .split_n(split_n), .sel(sel)
   );

   ttb_desc_addr #(
      .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .IDX_LSB(IDX_LSB)
   ) u_addr (
      .idx_bits(va_i[ADDR_W-1 -: IDX_W]),
      .base0_q(base0_q), .base1_q(base1_q), .base0_mask(base0_mask),
      .sel(sel), .desc_addr(desc_addr)
   );

   assign ctrl_rdata = {{(ADDR_W-SPLIT_W){1'b0}}, split_n};
   assign base1_sel  = (sel == TTB_SEL_HIGH);

   p_zero_split_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata == '0) |-> !base1_sel);

   p_word_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      desc_addr[IDX_LSB-1:0] == '0);

   p_high_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
      base1_sel |-> desc_addr[ALIGN_BITS-1:0] ==
                    {va_i[ADDR_W-1 -: IDX_W], {IDX_LSB{1'b0}}});

   p_rdata_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rdata[ADDR_W-1:SPLIT_W] == '0);

endmodule

// File: tb/test_ttb_select.sv
`timescale 1ns/1ps
module test_ttb_select;

   typedef struct packed {
      logic [31:0] b0;
      logic [31:0] b1;
      logic [2:0]  n;
      logic [31:0] va;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_4000, 32'h8000_0000, 3'd0, 32'hFFFF_FFFF},
      '{32'h1111_1111, 32'h2222_2222, 3'd1, 32'h8000_0000},
      '{32'h1111_1111, 32'h2222_2222, 3'd1, 32'h7FF0_0000},
      '{32'hDEAD_BEEF, 32'hCAFE_F00D, 3'd3, 32'h1000_0000},
      '{32'hDEAD_BEEF, 32'hCAFE_F00D, 3'd3, 32'h2000_0000},
      '{32'h0123_4567, 32'h89AB_CDEF, 3'd7, 32'h01FF_FFFF},
      '{32'h0123_4567, 32'h89AB_CDEF, 3'd7, 32'h0200_0000},
      '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd4, 32'h0FFF_FFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] va_i = '0;
   logic        base0_we = 1'b0, base1_we = 1'b0, ctrl_we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] ctrl_rdata, desc_addr;
   logic        base1_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ttb_select i_ttb_select (
      .clk(clk), .rst_n(rst_n), .va_i(va_i),
      .base0_we(base0_we), .base1_we(base1_we), .ctrl_we(ctrl_we),
      .wdata(wdata), .ctrl_rdata(ctrl_rdata),
      .desc_addr(desc_addr), .base1_sel(base1_sel)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // Expected lookup from the written requirements (R3..R6).
   function automatic void expect_of(input logic [31:0] b0, input logic [31:0] b1,
                                     input logic [2:0] n, input logic [31:0] va,
                                     output logic [31:0] d, output logic s);
      logic [31:0] base;
      s    = |(va & ~(32'hFFFF_FFFF >> n));
      base = s ? (b1 & 32'hFFFF_C000) : (b0 & ~(32'h0000_3FFF >> n));
      d    = base | ((va >> 18) & 32'h0000_3FFC);
   endfunction

   task automatic wr(input logic w0, input logic w1, input logic wc, input logic [31:0] d);
      @(negedge clk);
      base0_we = w0; base1_we = w1; ctrl_we = wc; wdata = d;
      @(negedge clk);
      base0_we = 1'b0; base1_we = 1'b0; ctrl_we = 1'b0;
   endtask

   task automatic look(input logic [31:0] va);
      va_i = va;
      #1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] ed;
      logic        es;
      repeat (3) @(negedge clk);
      // R1: reset state
      look(32'hFFF0_0000);
      chk("R1 rdata", ctrl_rdata, 32'h0);
      chk("R1 sel", {31'b0, base1_sel}, 32'h0);
      chk("R1 desc", desc_addr, 32'h0000_3FFC);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         wr(1'b1, 1'b0, 1'b0, VECS[i].b0);
         wr(1'b0, 1'b1, 1'b0, VECS[i].b1);
         wr(1'b0, 1'b0, 1'b1, {29'b0, VECS[i].n});
         look(VECS[i].va);
         expect_of(VECS[i].b0, VECS[i].b1, VECS[i].n, VECS[i].va, ed, es);
         chk("R3 table sel", {31'b0, base1_sel}, {31'b0, es});
         chk("R4/R5/R6 table desc", desc_addr, ed);
      end

      // R2: only low three bits kept
      wr(1'b0, 1'b0, 1'b1, 32'hFFFF_FFFD);
      chk("R2 rdata", ctrl_rdata, 32'h5);

      // R8: write and lookup in the same cycle
      @(negedge clk);
      va_i = 32'h0800_0000; ctrl_we = 1'b1; wdata = 32'h2;
      #1;
      chk("R8 old sel", {31'b0, base1_sel}, 32'h1);
      chk("R8 old rdata", ctrl_rdata, 32'h5);
      @(negedge clk);
      ctrl_we = 1'b0;
      #1;
      chk("R8 new sel", {31'b0, base1_sel}, 32'h0);
      chk("R8 new rdata", ctrl_rdata, 32'h2);

      // R7: stored base0 low bits reappear with larger N
      wr(1'b1, 1'b0, 1'b0, 32'h1234_5FFF);
      wr(1'b0, 1'b0, 1'b1, 32'h0);
      look(32'h0000_0000);
      chk("R7 N0 desc", desc_addr, 32'h1234_4000);
      wr(1'b0, 1'b0, 1'b1, 32'h7);
      look(32'h0000_0000);
      chk("R7 N7 desc", desc_addr, 32'h1234_5F80);
      look(32'h01F0_0000);
      chk("R6 N7 index", desc_addr, 32'h1234_5FFC);

      // R5: base1 alignment fixed
      wr(1'b0, 1'b1, 1'b0, 32'hABCD_EFFF);
      look(32'hFE00_0000);
      chk("R5 sel", {31'b0, base1_sel}, 32'h1);
      chk("R5 desc", desc_addr, 32'hABCD_FF80);

      // R9: three writes in one cycle
      @(negedge clk);
      base0_we = 1'b1; base1_we = 1'b1; ctrl_we = 1'b1; wdata = 32'h0000_8000;
      @(negedge clk);
      base0_we = 1'b0; ctrl_we = 1'b0; wdata = 32'h0001_0000;
      @(negedge clk);
      base1_we = 1'b0;
      // The shared-data write above stores N=0 and base1=0x8000, then base1=0x10000
      wr(1'b0, 1'b0, 1'b1, 32'h1);
      @(negedge clk);
      base0_we = 1'b1; base1_we = 1'b1; ctrl_we = 1'b1; wdata = 32'h0000_8001;
      @(negedge clk);
      base0_we = 1'b0; base1_we = 1'b0; ctrl_we = 1'b0;
      look(32'h8000_0000);
      chk("R9 high sel", {31'b0, base1_sel}, 32'h1);
      chk("R9 high desc", desc_addr, 32'h0000_A000);
      look(32'h7FFF_FFFF);
      chk("R9 low sel", {31'b0, base1_sel}, 32'h0);
      chk("R9 low desc", desc_addr, 32'h0000_9FFC);

      // R1: reset mid-run
      rst_n = 1'b0;
      look(32'hFFFF_FFFF);
      chk("R1 rerst rdata", ctrl_rdata, 32'h0);
      chk("R1 rerst sel", {31'b0, base1_sel}, 32'h0);
      chk("R1 rerst desc", desc_addr, 32'h0000_3FFC);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule